// File: doc/BRIEF.md
# SPI Addressed Memory Access Engine

This block is an SPI slave command interpreter that gives a host byte-wide access to an 11-bit address space. Behind that address space sit a configuration register file, a battery-backed RAM and a packet RAM. The block itself holds none of that storage. It drives a simple synchronous memory port: one address, write data, a write strobe and a read strobe. Read data comes back on the cycle after the read strobe.

Every transaction begins when chip select falls. The first byte is an opcode whose upper five bits pick the access type and whose low three bits carry address bits [10:8]. The second byte carries address bits [7:0].

Four access types are supported:
- Sequential block write.
- Sequential block read.
- Random-address write, which takes a fresh low address byte before each data byte.
- Random-address read, which takes a fresh low address byte before each data byte.

Read flows insert one dummy byte before valid data. Read data is fetched a byte ahead, so it is ready when the next byte starts.

SPI runs in mode 0: MOSI is sampled on the SCK rising edge and MISO changes after the falling edge. The SPI pins are sampled with the system clock and must already be synchronous to it. SCK high and low phases must each last at least four system clocks.

A host keeps bursts to 256 bytes in the register and packet regions and to 64 bytes in the battery-backed region. The engine does not police this limit.

Top module: `spi_mem_access`

## Requirements
- R1: An opcode byte with bits [7:3] = 00011 starts a block write. The next byte gives address bits [7:0] and opcode bits [2:0] give address bits [10:8]. The first data byte is written at that address.
- R2: In a block write, each further data byte is written one address higher than the previous one. The address wraps from 0x7FF to 0x000, and the burst continues until chip select rises.
- R3: The byte sequence 0x19, 0x3E, 0x00 writes 0x00 to address 0x13E.
- R4: An opcode with bits [7:3] = 00001 starts a random write. It then takes repeated (low address byte, data byte) pairs, with bits [10:8] fixed by the opcode. A later pair to the same address overwrites the earlier one.
- R5: An opcode with bits [7:3] = 00111 starts a block read.
  - The byte shifted out on MISO after the low address byte is a dummy 0x00.
  - The following byte carries the data at the start address, most significant bit first.
  - MISO does not change while SCK stays high.
- R6: In a block read, each further byte advances the read address by one, wrapping from 0x7FF to 0x000.
- R7: An opcode with bits [7:3] = 00101 starts a random read, made of repeated triplets: a low address byte, a dummy byte that shifts out 0x00, and a byte that shifts out the data at that address.
- R8: Chip select rising in the middle of a byte discards the partial byte, causes no memory write, and makes the next transaction decode its first byte as an opcode.
- R9: An opcode matching none of the four prefixes causes no memory access for the rest of the transaction, and MISO shifts out 0x00.
- R10: MISO is 0 out of reset, while chip select is high, and during opcode, address and write-data bytes.
- R11: The write and read strobes are single-cycle pulses, never high together, and neither is high out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low, synchronous to clk |
| spi_sck | input | 1 | SPI clock, mode 0, synchronous to clk |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| mem_addr | output | 11 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Write strobe, one cycle per byte |
| mem_re | output | 1 | Read strobe, one cycle per fetch |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |

## Verification
The hardest situation to reach from the ports is chip select rising partway through a data byte of a write burst that is already running. At that point a write is one rising edge away and the sequencer is sitting in its data phase. To get there, the stimulus clocks out only a few bits of a data byte and then deselects. It then opens a fresh block read of the same address at once. This read shows two things: that the old value survived, and that the first new byte was decoded as an opcode rather than as leftover data. The same abort is also applied inside an opcode byte, and reads are started near 0x7FF so the one-byte-ahead fetch crosses the wrap point.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 11;
    localparam int HI_W   = ADDR_W - BYTE_W;
    localparam int OPC_W  = BYTE_W - HI_W;

    // Opcode prefixes (upper bits of the first byte)
    localparam logic [OPC_W-1:0] OPC_BLK_WR = 5'b00011;
    localparam logic [OPC_W-1:0] OPC_RND_WR = 5'b00001;
    localparam logic [OPC_W-1:0] OPC_BLK_RD = 5'b00111;
    localparam logic [OPC_W-1:0] OPC_RND_RD = 5'b00101;

    typedef enum logic [1:0] {
        XK_BLK_WR,
        XK_RND_WR,
        XK_BLK_RD,
        XK_RND_RD
    } xfer_kind_e;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_WDATA,
        PH_DUMMY,
        PH_RDATA,
        PH_SINK
    } phase_e;

    typedef struct packed {
        logic       valid;
        xfer_kind_e kind;
    } opc_dec_t;

    function automatic opc_dec_t decode_opcode(input logic [OPC_W-1:0] prefix);
        opc_dec_t d;
        d.valid = 1'b1;
        d.kind  = XK_BLK_WR;
        case (prefix)
            OPC_BLK_WR: d.kind = XK_BLK_WR;
            OPC_RND_WR: d.kind = XK_RND_WR;
            OPC_BLK_RD: d.kind = XK_BLK_RD;
            OPC_RND_RD: d.kind = XK_RND_RD;
            default:    d.valid = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic kind_reads(input xfer_kind_e k);
        return (k == XK_BLK_RD) || (k == XK_RND_RD);
    endfunction

endpackage

// File: rtl/spi_byte_link.sv
module spi_byte_link
    import spi_mem_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          mosi,
    input  logic [DW-1:0] tx_byte,
    output logic          miso,
    output logic          rx_valid,
    output logic [DW-1:0] rx_byte
);

    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    logic          sck_q;
    logic          rise_evt;
    logic          fall_evt;
    logic [CW-1:0] bit_cnt;
    logic [DW-1:0] rx_sh;
    logic [DW-1:0] tx_sh;

    assign rise_evt = sck & ~sck_q & ~cs_n;
    assign fall_evt = ~sck & sck_q & ~cs_n;
    assign miso     = tx_sh[DW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            sck_q    <= sck;
            rx_valid <= 1'b0;
            if (cs_n) begin
                bit_cnt <= '0;
                tx_sh   <= '0;
            end else begin
                if (rise_evt) begin
                    rx_sh <= {rx_sh[DW-2:0], mosi};
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt  <= '0;
                        rx_valid <= 1'b1;
                        rx_byte  <= {rx_sh[DW-2:0], mosi};
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (fall_evt) begin
                    if (bit_cnt == '0) tx_sh <= tx_byte;
                    else               tx_sh <= {tx_sh[DW-2:0], 1'b0};
                end
            end
        end
    end

    // R5
    miso_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sck && sck_q && !cs_n) |=> $stable(miso));

    // R8
    rx_gap_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

endmodule

// File: rtl/spi_mem_sequencer.sv
module spi_mem_sequencer
    import spi_mem_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] tx_byte,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          mem_re
);

    localparam int HW = AW - DW;

    phase_e        phase_q;
    xfer_kind_e    kind_q;
    logic [HW-1:0] hi_q;
    logic [AW-1:0] ptr_q;
    logic [DW-1:0] prefetch_q;
    logic          fetch_pend;
    logic [AW-1:0] rx_addr;
    opc_dec_t      dec;

    assign rx_addr = {hi_q, rx_byte};
    assign dec     = decode_opcode(rx_byte[DW-1:HW]);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_OPC;
            kind_q     <= XK_BLK_WR;
            hi_q       <= '0;
            ptr_q      <= '0;
            prefetch_q <= '0;
            fetch_pend <= 1'b0;
            tx_byte    <= '0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
            mem_we     <= 1'b0;
            mem_re     <= 1'b0;
        end else begin
            mem_we     <= 1'b0;
            mem_re     <= 1'b0;
            fetch_pend <= mem_re;
            if (fetch_pend) prefetch_q <= mem_rdata;
            if (cs_n) begin
                phase_q <= PH_OPC;
                tx_byte <= '0;
            end else if (rx_valid) begin
                case (phase_q)
                    PH_OPC: begin
                        if (dec.valid) begin
                            kind_q  <= dec.kind;
                            hi_q    <= rx_byte[HW-1:0];
                            phase_q <= PH_ADDR;
                        end else begin
                            phase_q <= PH_SINK;
                        end
                    end
                    PH_ADDR: begin
                        if (kind_reads(kind_q)) begin
                            mem_re   <= 1'b1;
                            mem_addr <= rx_addr;
                            ptr_q    <= rx_addr + 1'b1;
                            tx_byte  <= '0;
                            phase_q  <= PH_DUMMY;
                        end else begin
                            ptr_q   <= rx_addr;
                            phase_q <= PH_WDATA;
                        end
                    end
                    PH_WDATA: begin
                        mem_we    <= 1'b1;
                        mem_addr  <= ptr_q;
                        mem_wdata <= rx_byte;
                        if (kind_q == XK_BLK_WR) ptr_q   <= ptr_q + 1'b1;
                        else                     phase_q <= PH_ADDR;
                    end
                    PH_DUMMY: begin
                        tx_byte <= prefetch_q;
                        if (kind_q == XK_BLK_RD) begin
                            mem_re   <= 1'b1;
                            mem_addr <= ptr_q;
                            ptr_q    <= ptr_q + 1'b1;
                        end
                        phase_q <= PH_RDATA;
                    end
                    PH_RDATA: begin
                        if (kind_q == XK_BLK_RD) begin
                            tx_byte  <= prefetch_q;
                            mem_re   <= 1'b1;
                            mem_addr <= ptr_q;
                            ptr_q    <= ptr_q + 1'b1;
                        end else begin
                            tx_byte <= '0;
                            phase_q <= PH_ADDR;
                        end
                    end
                    default: phase_q <= PH_SINK;
                endcase
            end
        end
    end

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R11
    we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R8
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!mem_we && !mem_re));

    // R9
    sink_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SINK) |-> (!mem_we && !mem_re));

endmodule

// File: rtl/spi_mem_access.sv
module spi_mem_access
    import spi_mem_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          spi_cs_n,
    input  logic          spi_sck,
    input  logic          spi_mosi,
    output logic          spi_miso,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    input  logic [DW-1:0] mem_rdata
);

    logic          rx_valid;
    logic [DW-1:0] rx_byte;
    logic [DW-1:0] tx_byte;

    spi_byte_link #(.DW(DW)) u_link (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (spi_cs_n),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .tx_byte  (tx_byte),
        .miso     (spi_miso),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte)
    );

    spi_mem_sequencer #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (spi_cs_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .mem_rdata (mem_rdata),
        .tx_byte   (tx_byte),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re)
    );

endmodule

// File: tb/spi_mem_access_bench.sv
module spi_mem_access_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 4;
    localparam int DEPTH      = 2048;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_cs_n = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [10:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_rdata = 8'h00;

    logic [7:0] ram     [0:DEPTH-1];
    logic [7:0] exp_mem [0:DEPTH-1];
    logic [7:0] exp_q [$];
    string      req_q [$];
    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_mem_access u_spi_mem_access (
        .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= ram[mem_addr];
    end

    // Monitor: assemble MISO bytes, compare against the scoreboard queue
    logic [7:0] mon_sh  = 8'h00;
    int         mon_cnt = 0;
    always @(posedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            mon_cnt = 0;
        end else begin
            mon_sh  = {mon_sh[6:0], spi_miso};
            mon_cnt = mon_cnt + 1;
            if (mon_cnt == 8) begin
                mon_cnt = 0;
                vectors++;
                if (exp_q.size() == 0) begin
                    miscompares++;
                    $display("FAIL R10: unexpected miso byte got %02h expected none", mon_sh);
                end else begin
                    logic [7:0] e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    if (mon_sh !== e) begin
                        miscompares++;
                        $display("FAIL %s: miso byte got %02h expected %02h", r, mon_sh, e);
                    end
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            spi_mosi = b[i];
            tick(HALF_SCK);
            spi_sck = 1'b1;
            tick(HALF_SCK);
            spi_sck = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic [7:0] miso_exp, input string r);
        exp_q.push_back(miso_exp);
        req_q.push_back(r);
        send_bits(b, 8);
    endtask

    task automatic cs_open();
        spi_cs_n = 1'b0;
        tick(HALF_SCK);
    endtask

    task automatic cs_close();
        tick(HALF_SCK);
        spi_cs_n = 1'b1;
        tick(3 * HALF_SCK);
    endtask

    task automatic check_mem(input logic [10:0] a, input string r);
        vectors++;
        if (ram[a] !== exp_mem[a]) begin
            miscompares++;
            $display("FAIL %s: mem[%03h] got %02h expected %02h", r, a, ram[a], exp_mem[a]);
        end
    endtask

    task automatic blk_write(input logic [2:0] hi, input logic [7:0] lo,
                             input int n, input logic [7:0] seed);
        logic [10:0] a;
        a = {hi, lo};
        cs_open();
        send_byte({5'b00011, hi}, 8'h00, "R1");
        send_byte(lo, 8'h00, "R10");
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = seed + 8'(i * 13);
            send_byte(d, 8'h00, "R10");
            exp_mem[a] = d;
            a = a + 1'b1;
        end
        cs_close();
    endtask

    task automatic blk_read(input logic [2:0] hi, input logic [7:0] lo, input int n);
        logic [10:0] a;
        a = {hi, lo};
        cs_open();
        send_byte({5'b00111, hi}, 8'h00, "R10");
        send_byte(lo, 8'h00, "R10");
        send_byte(8'h00, 8'h00, "R5");
        for (int i = 0; i < n; i++) begin
            send_byte(8'h00, exp_mem[a], (i == 0) ? "R5" : "R6");
            a = a + 1'b1;
        end
        cs_close();
    endtask

    task automatic rnd_read3(input logic [2:0] hi, input logic [7:0] l0,
                             input logic [7:0] l1, input logic [7:0] l2);
        logic [7:0] lows [3];
        lows[0] = l0; lows[1] = l1; lows[2] = l2;
        cs_open();
        send_byte({5'b00101, hi}, 8'h00, "R10");
        for (int i = 0; i < 3; i++) begin
            send_byte(lows[i], 8'h00, "R7");
            send_byte(8'h00, 8'h00, "R7");
            send_byte(8'h00, exp_mem[{hi, lows[i]}], "R7");
        end
        cs_close();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        miscompares++;
        $display("FAIL R11: watchdog got %0d cycles expected completion", WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ram[i]     = 8'(i * 37 + (i >> 5));
            exp_mem[i] = 8'(i * 37 + (i >> 5));
        end
        tick(5);
        rst = 1'b0;
        tick(2);

        // Reset state: R10, R11
        vectors++;
        if (spi_miso !== 1'b0 || mem_we !== 1'b0 || mem_re !== 1'b0) begin
            miscompares++;
            $display("FAIL R11: reset outputs got %b%b%b expected 000", spi_miso, mem_we, mem_re);
        end

        // R3: literal byte sequence
        cs_open();
        send_byte(8'h19, 8'h00, "R3");
        send_byte(8'h3E, 8'h00, "R3");
        send_byte(8'h00, 8'h00, "R3");
        cs_close();
        exp_mem[11'h13E] = 8'h00;
        check_mem(11'h13E, "R3");

        // R1 and R2: block write, plain and across the top of the space
        blk_write(3'd2, 8'h10, 5, 8'h5A);
        for (int i = 0; i < 5; i++) check_mem(11'h210 + 11'(i), (i == 0) ? "R1" : "R2");
        blk_write(3'd7, 8'hFE, 4, 8'hC1);
        check_mem(11'h7FE, "R2");
        check_mem(11'h7FF, "R2");
        check_mem(11'h000, "R2");
        check_mem(11'h001, "R2");

        // R4: random write pairs, last one to 0x305 wins
        cs_open();
        send_byte({5'b00001, 3'd3}, 8'h00, "R4");
        send_byte(8'h05, 8'h00, "R4"); send_byte(8'hA1, 8'h00, "R4");
        send_byte(8'h80, 8'h00, "R4"); send_byte(8'hB2, 8'h00, "R4");
        send_byte(8'h05, 8'h00, "R4"); send_byte(8'hC3, 8'h00, "R4");
        cs_close();
        exp_mem[11'h305] = 8'hC3;
        exp_mem[11'h380] = 8'hB2;
        check_mem(11'h305, "R4");
        check_mem(11'h380, "R4");
        check_mem(11'h306, "R4");

        // R5 and R6: block reads, including one across the wrap
        blk_read(3'd2, 8'h10, 6);
        blk_read(3'd7, 8'hFD, 5);
        blk_read(3'd1, 8'h3E, 1);

        // R7: random read triplets
        rnd_read3(3'd3, 8'h80, 8'h05, 8'h06);

        // R8: abort inside a write data byte, then read back at once
        cs_open();
        send_byte({5'b00011, 3'd4}, 8'h00, "R8");
        send_byte(8'h20, 8'h00, "R8");
        send_bits(8'hFF, 5);
        cs_close();
        check_mem(11'h420, "R8");
        blk_read(3'd4, 8'h20, 2);

        // R8: abort inside an opcode byte, next transaction still decodes
        cs_open();
        send_bits(8'h3F, 3);
        cs_close();
        blk_write(3'd5, 8'h44, 1, 8'h77);
        check_mem(11'h544, "R8");

        // R9: unknown opcode, bytes that would look like address and data
        cs_open();
        send_byte(8'hF5, 8'h00, "R9");
        send_byte(8'h20, 8'h00, "R9");
        send_byte(8'h55, 8'h00, "R9");
        send_byte(8'h66, 8'h00, "R9");
        cs_close();

        // Whole memory versus model: no stray writes (R9, R8)
        for (int i = 0; i < DEPTH; i++) check_mem(11'(i), "R9");

        // Every expected MISO byte consumed
        tick(4);
        vectors++;
        if (exp_q.size() != 0) begin
            miscompares++;
            $display("FAIL R5: pending miso bytes got %0d expected 0", exp_q.size());
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule